// File: doc/BRIEF.md
# Time-Compare Sync Pulse Generator

This block watches a free-running 64-bit system time, already kept in step across the network by other logic, and raises timed pulses on two independent channels when that time reaches a programmed start value. Each channel is either one-shot or cyclic. A one-shot channel fires once and then goes idle. A cyclic channel reloads its own compare value after every firing, so it produces a periodic pulse train locked to absolute time.

Software configures each channel through a simple write port: start time, cycle time, mode, enable and pulse length. Each pulse also sets a sticky per-channel interrupt request that software clears with an acknowledge write. A pulse length of zero turns the output into a level that stays high until it is acknowledged. The pulses are meant to trigger the sampling of inputs just before a frame passes, or the latching of outputs just after it. That downstream action is not part of this block.

Top module: `tcmp_sync_top`

## Requirements
- R1: While reset is applied, and after it is released with no write, both sync outputs and both interrupt requests are low.
- R2: An armed channel fires on the first clock edge at which the sampled system time is greater than or equal to its compare value. Its sync output is high in the cycle that follows that edge, even when the time skips over the exact compare value.
- R3: In one-shot mode (control bit 1 = 0) a channel fires exactly once per arming and then stays idle.
- R4: In cyclic mode (control bit 1 = 1, cycle time nonzero), each new compare value is the previous compare value plus the cycle time. It is never derived from the time at which the channel fired, so rounding to the time step does not build up.
- R5: In cyclic mode with a cycle time of 0, the channel behaves as one-shot.
- R6: With a pulse length N > 0, the sync output stays high for exactly N clock cycles per firing.
- R7: With a pulse length of 0, the sync output stays high after firing until an acknowledge write to that channel. That write drops it on the same edge.
- R8: Each firing sets the channel's interrupt request, which stays set until an acknowledge write (field 4) to that channel.
- R9: A control write with enable (bit 0) = 0 discards any pending compare, and drives that channel's sync output and interrupt request low on the edge of the write. No later pulse occurs until the channel is re-armed.
- R10: If the start time has already passed when the channel is armed, it fires on the first edge after the arming write.
- R11: The two channels are independent. Writes to one, and pulses on one, leave the other's outputs unchanged.
- R12: The write address is {channel, field[2:0]}, with fields 0 start time (64 bits), 1 cycle time, 2 control (bit 0 enable, bit 1 cyclic), 3 pulse length and 4 acknowledge. A control write with enable = 1 arms the channel using the start-time register as held at that moment. Later start-time writes take effect only at the next arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sys_time_i | input | TIME_W (64) | Synchronized system time |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | CH_W+3 | Register address {channel, field} |
| wr_data_i | input | TIME_W (64) | Register write data |
| sync_o | output | NCH (2) | Sync pulse per channel |
| irq_o | output | NCH (2) | Sticky interrupt request per channel |

## Verification
The bench drives the time in steps of 10, so start times that are not multiples of 10 test the greater-or-equal compare. A design that used equality would never fire. In cyclic mode it uses a cycle time of 125, where a reload taken from the firing time would drift a step late within a few periods and miss the expected times. It disables a channel in the middle of a long pulse and while a compare is still pending. A design that left the pulse counter running, or kept the pending compare, would show a late level or a stray pulse. It also covers a start time already in the past, a zero cycle time in cyclic mode, the hold-until-acknowledge level, and a start-time rewrite without re-arming. These catch designs that wait for a time wrap, loop on a zero period, let the level run on, or load the start value too eagerly.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;

  localparam int FIELD_W = 3;

  typedef enum logic [FIELD_W-1:0] {
    FLD_START = 3'd0,
    FLD_CYCLE = 3'd1,
    FLD_CTRL  = 3'd2,
    FLD_PLEN  = 3'd3,
    FLD_ACK   = 3'd4
  } fld_e;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_CYC_BIT = 1;

endpackage

// File: rtl/tcmp_regs.sv
module tcmp_regs
  import tcmp_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int TIME_W = 64,
  parameter int CYC_W  = 32,
  parameter int PLEN_W = 16,
  parameter int CH_W   = 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en_i,
  input  logic [CH_W+FIELD_W-1:0]      wr_addr_i,
  input  logic [TIME_W-1:0]            wr_data_i,
  output logic [NCH-1:0][TIME_W-1:0]   start_o,
  output logic [NCH-1:0][CYC_W-1:0]    cycle_o,
  output logic [NCH-1:0]               cyclic_o,
  output logic [NCH-1:0][PLEN_W-1:0]   plen_o,
  output logic [NCH-1:0]               arm_o,
  output logic [NCH-1:0]               disarm_o,
  output logic [NCH-1:0]               ack_o
);

  localparam int ADDR_W = CH_W + FIELD_W;

  logic [CH_W-1:0] sel_ch;
  fld_e            sel_fld;

  assign sel_ch  = wr_addr_i[ADDR_W-1:FIELD_W];
  assign sel_fld = fld_e'(wr_addr_i[FIELD_W-1:0]);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic              hit;
    logic [TIME_W-1:0] start_q, start_d;
    logic [CYC_W-1:0]  cycle_q, cycle_d;
    logic              cyclic_q, cyclic_d;
    logic [PLEN_W-1:0] plen_q, plen_d;

    assign hit = wr_en_i && (sel_ch == CH_W'(c));

    always_comb begin
      start_d  = start_q;
      cycle_d  = cycle_q;
      cyclic_d = cyclic_q;
      plen_d   = plen_q;
      if (hit) begin
        case (sel_fld)
          FLD_START: start_d  = wr_data_i;
          FLD_CYCLE: cycle_d  = wr_data_i[CYC_W-1:0];
          FLD_CTRL:  cyclic_d = wr_data_i[CTRL_CYC_BIT];
          FLD_PLEN:  plen_d   = wr_data_i[PLEN_W-1:0];
          default: ;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        start_q  <= '0;
        cycle_q  <= '0;
        cyclic_q <= 1'b0;
        plen_q   <= '0;
      end else if (hit) begin
        start_q  <= start_d;
        cycle_q  <= cycle_d;
        cyclic_q <= cyclic_d;
        plen_q   <= plen_d;
      end
    end

    assign start_o[c]  = start_q;
    assign cycle_o[c]  = cycle_q;
    assign cyclic_o[c] = cyclic_q;
    assign plen_o[c]   = plen_q;
    assign arm_o[c]    = hit && (sel_fld == FLD_CTRL) &&  wr_data_i[CTRL_EN_BIT];
    assign disarm_o[c] = hit && (sel_fld == FLD_CTRL) && !wr_data_i[CTRL_EN_BIT];
    assign ack_o[c]    = hit && (sel_fld == FLD_ACK);
  end

endmodule

// File: rtl/tcmp_chan.sv
module tcmp_chan #(
  parameter int TIME_W = 64,
  parameter int CYC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] sys_time_i,
  input  logic [TIME_W-1:0] start_i,
  input  logic [CYC_W-1:0]  cycle_i,
  input  logic              cyclic_i,
  input  logic              arm_i,
  input  logic              disarm_i,
  output logic              fire_o
);

  logic              pending_q, pending_d;
  logic [TIME_W-1:0] cmp_q, cmp_d;
  logic              reached;
  logic              reload;

  assign reached = pending_q && (sys_time_i >= cmp_q);
  assign reload  = cyclic_i && (cycle_i != '0);
  assign fire_o  = reached && !arm_i && !disarm_i;

  always_comb begin
    pending_d = pending_q;
    cmp_d     = cmp_q;
    if (disarm_i) begin
      pending_d = 1'b0;
    end else if (arm_i) begin
      pending_d = 1'b1;
      cmp_d     = start_i;
    end else if (reached) begin
      if (reload) begin
        cmp_d = cmp_q + TIME_W'(cycle_i);
      end else begin
        pending_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      cmp_q     <= '0;
    end else begin
      pending_q <= pending_d;
      cmp_q     <= cmp_d;
    end
  end

  AST_ONESHOT_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_o && !cyclic_i) |=> !pending_q); // R3

  AST_CYCLIC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_o && cyclic_i && cycle_i != '0) |=> (pending_q && cmp_q == $past(cmp_q) + TIME_W'($past(cycle_i)))); // R4

  AST_ARM_LOADS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_i && !disarm_i) |=> (pending_q && cmp_q == $past(start_i))); // R12

  AST_DISARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    disarm_i |=> !pending_q); // R9

endmodule

// File: rtl/tcmp_pulse.sv
module tcmp_pulse #(
  parameter int PLEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  input  logic              ack_i,
  input  logic              disarm_i,
  input  logic [PLEN_W-1:0] plen_i,
  output logic              sync_o,
  output logic              irq_o
);

  logic [PLEN_W-1:0] cnt_q, cnt_d;
  logic              hold_q, hold_d;
  logic              irq_q, irq_d;

  always_comb begin
    cnt_d  = cnt_q;
    hold_d = hold_q;
    irq_d  = irq_q;
    if (disarm_i) begin
      cnt_d  = '0;
      hold_d = 1'b0;
      irq_d  = 1'b0;
    end else if (fire_i) begin
      irq_d = 1'b1;
      if (plen_i == '0) begin
        hold_d = 1'b1;
        cnt_d  = '0;
      end else begin
        hold_d = 1'b0;
        cnt_d  = plen_i;
      end
    end else begin
      if (cnt_q != '0) begin
        cnt_d = cnt_q - 1'b1;
      end
      if (ack_i) begin
        hold_d = 1'b0;
        irq_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
      irq_q  <= irq_d;
    end
  end

  assign sync_o = hold_q || (cnt_q != '0);
  assign irq_o  = irq_q;

  AST_HOLD_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !ack_i && !disarm_i) |=> sync_o); // R7

  AST_FIRE_SETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && !disarm_i) |=> (irq_o && sync_o)); // R8

  AST_DISARM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    disarm_i |=> (!sync_o && !irq_o)); // R9

  AST_PULSE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire_i && !hold_q && cnt_q == PLEN_W'(1)) |=> !sync_o); // R6

endmodule

// File: rtl/tcmp_sync_top.sv
module tcmp_sync_top
  import tcmp_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int TIME_W = 64,
  parameter int CYC_W  = 32,
  parameter int PLEN_W = 16,
  parameter int CH_W   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [TIME_W-1:0]         sys_time_i,
  input  logic                      wr_en_i,
  input  logic [CH_W+FIELD_W-1:0]   wr_addr_i,
  input  logic [TIME_W-1:0]         wr_data_i,
  output logic [NCH-1:0]            sync_o,
  output logic [NCH-1:0]            irq_o
);

  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe_q[1];

  logic [NCH-1:0][TIME_W-1:0] start_w;
  logic [NCH-1:0][CYC_W-1:0]  cycle_w;
  logic [NCH-1:0]             cyclic_w;
  logic [NCH-1:0][PLEN_W-1:0] plen_w;
  logic [NCH-1:0]             arm_w;
  logic [NCH-1:0]             disarm_w;
  logic [NCH-1:0]             ack_w;
  logic [NCH-1:0]             fire_w;

  tcmp_regs #(
    .NCH   (NCH),
    .TIME_W(TIME_W),
    .CYC_W (CYC_W),
    .PLEN_W(PLEN_W),
    .CH_W  (CH_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .start_o  (start_w),
    .cycle_o  (cycle_w),
    .cyclic_o (cyclic_w),
    .plen_o   (plen_w),
    .arm_o    (arm_w),
    .disarm_o (disarm_w),
    .ack_o    (ack_w)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tcmp_chan #(
      .TIME_W(TIME_W),
      .CYC_W (CYC_W)
    ) u_chan (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .sys_time_i(sys_time_i),
      .start_i   (start_w[c]),
      .cycle_i   (cycle_w[c]),
      .cyclic_i  (cyclic_w[c]),
      .arm_i     (arm_w[c]),
      .disarm_i  (disarm_w[c]),
      .fire_o    (fire_w[c])
    );

    tcmp_pulse #(
      .PLEN_W(PLEN_W)
    ) u_pulse (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .fire_i  (fire_w[c]),
      .ack_i   (ack_w[c]),
      .disarm_i(disarm_w[c]),
      .plen_i  (plen_w[c]),
      .sync_o  (sync_o[c]),
      .irq_o   (irq_o[c])
    );
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_sync_n |=> (sync_o == '0 && irq_o == '0)); // R1

endmodule

// File: tb/sim_tcmp_sync_top.sv
module sim_tcmp_sync_top;

  localparam int STEP = 10;

  typedef struct packed {
    logic [63:0] t;
    logic [31:0] w;
  } item_t;

  logic        clk;
  logic        rst_n;
  logic [63:0] sys_time;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [63:0] wr_data;
  logic [1:0]  sync;
  logic [1:0]  irq;

  int errors = 0;
  int checks = 0;

  tcmp_sync_top u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .sys_time_i(sys_time),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .sync_o    (sync),
    .irq_o     (irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial sys_time = 64'd0;
  always @(negedge clk) sys_time <= sys_time + 64'(STEP);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] ceil_step(input logic [63:0] x);
    return ((x + 64'(STEP - 1)) / 64'(STEP)) * 64'(STEP);
  endfunction

  // scoreboard monitor: one per channel, sampled 2 ns after the rising edge
  for (genvar c = 0; c < 2; c++) begin : mon
    item_t q[$];
    item_t cur;
    logic  prv;
    int    run;
    int    rises;
    initial begin
      prv = 1'b0; run = 0; rises = 0; cur = '0;
    end
    always @(posedge clk) begin
      #2;
      if (rst_n) begin
        if (sync[c] && !prv) begin
          rises++;
          if (q.size() == 0) begin
            chk($sformatf("R3/R9 ch%0d unexpected pulse at time", c), sys_time, 64'hFFFF_FFFF_FFFF_FFFF);
            cur = '0;
          end else begin
            cur = q.pop_front();
            chk($sformatf("R2/R4 ch%0d fire time", c), sys_time, cur.t);
          end
        end
        if (sync[c]) run++;
        if (!sync[c] && prv) begin
          if (cur.w != 0) chk($sformatf("R6 ch%0d pulse width", c), 64'(run), 64'(cur.w));
          run = 0;
        end
        prv = sync[c];
      end
    end
  end

  task automatic expect_pulse(input int ch, input logic [63:0] t, input int w);
    item_t it;
    it.t = t;
    it.w = 32'(w);
    if (ch == 0) mon[0].q.push_back(it);
    else         mon[1].q.push_back(it);
  endtask

  task automatic wr(input int ch, input logic [2:0] f, input logic [63:0] d, output logic [63:0] tp);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = {ch[0], f};
    wr_data = d;
    @(posedge clk);
    tp = sys_time;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setup(input int ch, input logic [63:0] start, input logic [63:0] cyc, input logic [63:0] plen);
    logic [63:0] tp;
    wr(ch, 3'd3, plen, tp);
    wr(ch, 3'd1, cyc, tp);
    wr(ch, 3'd0, start, tp);
  endtask

  task automatic wait_time(input logic [63:0] t);
    while (sys_time < t) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [63:0] tp, now, s0, s1, ft;
    int r0, r1;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (4) @(negedge clk);
    chk("R1 sync during reset", 64'(sync), 64'd0);
    chk("R1 irq during reset", 64'(irq), 64'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 sync after reset", 64'(sync), 64'd0);
    chk("R1 irq after reset", 64'(irq), 64'd0);

    // R2 R3 R6: one-shot, start off the time grid
    now = sys_time;
    s0 = now + 64'd205;
    setup(0, s0, 64'd0, 64'd3);
    wr(0, 3'd2, 64'd1, tp);
    expect_pulse(0, ceil_step(s0), 3);
    wait_time(s0 + 64'd300);
    chk("R3 one-shot fired once", 64'(mon[0].rises), 64'd1);
    chk("R8 irq set after fire", 64'(irq[0]), 64'd1);
    wr(0, 3'd4, 64'd0, tp);
    chk("R8 irq cleared by ack", 64'(irq[0]), 64'd0);

    // R4 R11: ch1 cyclic with off-grid period, ch0 one-shot overlapping
    now = sys_time;
    s1 = now + 64'd203;
    s0 = now + 64'd257;
    setup(1, s1, 64'd125, 64'd2);
    setup(0, s0, 64'd0, 64'd5);
    wr(1, 3'd2, 64'd3, tp);
    for (int k = 0; k < 4; k++) expect_pulse(1, ceil_step(s1 + 64'(k * 125)), 2);
    wr(0, 3'd2, 64'd1, tp);
    expect_pulse(0, ceil_step(s0), 5);
    wait_time(ceil_step(s1 + 64'd375) + 64'd40);
    wr(1, 3'd2, 64'd0, tp);
    wait_time(s1 + 64'd750);
    chk("R4 cyclic pulse count", 64'(mon[1].rises), 64'd4);
    chk("R11 ch0 pulses", 64'(mon[0].rises), 64'd2);
    chk("R9 irq1 cleared by disable", 64'(irq[1]), 64'd0);
    chk("R11 irq0 set by ch0", 64'(irq[0]), 64'd1);
    wr(0, 3'd4, 64'd0, tp);
    chk("R11 ack on ch0 leaves ch1", 64'(irq), 64'd0);

    // R5: cyclic with zero period acts once
    r0 = mon[0].rises;
    now = sys_time;
    s0 = now + 64'd150;
    setup(0, s0, 64'd0, 64'd1);
    wr(0, 3'd2, 64'd3, tp);
    expect_pulse(0, ceil_step(s0), 1);
    wait_time(s0 + 64'd400);
    chk("R5 zero cycle fires once", 64'(mon[0].rises - r0), 64'd1);
    wr(0, 3'd2, 64'd0, tp);

    // R7: hold-until-ack level
    now = sys_time;
    s1 = now + 64'd100;
    setup(1, s1, 64'd0, 64'd0);
    wr(1, 3'd2, 64'd1, tp);
    expect_pulse(1, ceil_step(s1), 0);
    wait_time(s1 + 64'd200);
    chk("R7 level held", 64'(sync[1]), 64'd1);
    chk("R8 irq with level", 64'(irq[1]), 64'd1);
    wr(1, 3'd4, 64'd0, tp);
    chk("R7 level dropped by ack", 64'(sync[1]), 64'd0);
    chk("R8 irq dropped by ack", 64'(irq[1]), 64'd0);

    // R9: disable in the middle of a long pulse
    now = sys_time;
    s0 = now + 64'd100;
    setup(0, s0, 64'd0, 64'd50);
    wr(0, 3'd2, 64'd1, tp);
    expect_pulse(0, ceil_step(s0), 0);
    wait_time(ceil_step(s0) + 64'd50);
    chk("R6 long pulse still high", 64'(sync[0]), 64'd1);
    wr(0, 3'd2, 64'd0, tp);
    chk("R9 sync low after disable", 64'(sync[0]), 64'd0);
    chk("R9 irq low after disable", 64'(irq[0]), 64'd0);

    // R9: disable discards a pending compare
    r1 = mon[1].rises;
    now = sys_time;
    setup(1, now + 64'd300, 64'd0, 64'd2);
    wr(1, 3'd2, 64'd1, tp);
    wr(1, 3'd2, 64'd0, tp);
    wait_time(now + 64'd600);
    chk("R9 no pulse after disable", 64'(mon[1].rises - r1), 64'd0);

    // R12: start rewrite without re-arm keeps the armed compare
    r1 = mon[1].rises;
    now = sys_time;
    s1 = now + 64'd200;
    setup(1, s1, 64'd0, 64'd1);
    wr(1, 3'd2, 64'd1, tp);
    wr(1, 3'd0, now + 64'd600, tp);
    expect_pulse(1, ceil_step(s1), 1);
    wait_time(now + 64'd800);
    chk("R12 armed compare kept", 64'(mon[1].rises - r1), 64'd1);

    // R10: start already in the past
    r0 = mon[0].rises;
    setup(0, 64'd5, 64'd0, 64'd2);
    wr(0, 3'd2, 64'd1, tp);
    ft = tp + 64'(STEP);
    expect_pulse(0, ft, 2);
    wait_time(ft + 64'd100);
    chk("R10 past start fires once", 64'(mon[0].rises - r0), 64'd1);

    chk("R2 ch0 all expected pulses seen", 64'(mon[0].q.size()), 64'd0);
    chk("R2 ch1 all expected pulses seen", 64'(mon[1].q.size()), 64'd0);
    summary();
    $finish;
  end

endmodule